// File: doc/BRIEF.md
# RC5 Round-Key Expansion Unit

This unit turns one secret key into the full set of round-key words that an RC5 cipher core with 32-bit words needs. For the default configuration of 12 rounds and a 16-byte key, that is 26 words. The expanded words go into a small local table. The cipher core then reads them by round number, so no key work happens while data is being encrypted or decrypted. A new key is offered with a key-available level from the source and taken with a one-cycle key-read acknowledge. After that the unit runs two phases back to back: it fills the table with its fixed starting pattern, then it runs the mixing loop at one iteration per clock. While the loop runs, the iteration index is shown on an output. When the loop ends, a ready flag rises.

The controller has five states. KS_IDLE is the state after reset. KS_LOAD is the acknowledge cycle. KS_INIT fills the table. KS_MIX runs the mixing loop. KS_READY means the keys are valid. The transitions are:
- KS_IDLE to KS_LOAD on key-available.
- KS_LOAD to KS_INIT always, after one cycle.
- KS_INIT to KS_MIX when the last table word has been written.
- KS_MIX to KS_READY after the last iteration.
- KS_READY to KS_LOAD on key-available.

Key-available is not sampled in KS_LOAD, KS_INIT or KS_MIX.

Top module: `rc5_keysched`

## Requirements
- R1: After reset, key_read, keys_ready and cycle_num are all 0.
- R2: The unit samples key_avail high at a rising edge only while it is idle or ready. key_read is then 1 for exactly the following clock cycle. key_in is captured at the edge that ends that cycle. Key byte n is on key_in[8n+7:8n]. Bytes are packed little-endian into 32-bit words, so byte 4k is the least significant byte of word L[k].
- R3: Before mixing, table word S[i] is set to 0xB7E15163 + i*0x9E3779B9 (mod 2^32), for i = 0..25.
- R4: Mixing starts with A = B = 0 and i = j = 0, and runs 78 iterations. Each iteration does the following, with all sums mod 2^32:
  - A = S[i] = rotl(S[i]+A+B, 3)
  - B = L[j] = rotl(L[j]+A+B, (A+B) mod 32)
  - i = (i+1) mod 26
  - j = (j+1) mod 4
- R5: keys_ready goes high right after the 106th rising edge, counting the edge that accepted the key as the first.
- R6: During mixing, cycle_num equals the index (0..77) of the iteration in progress. In every other state it is 0.
- R7: keys_ready stays high until a new key is accepted. It is 0 during the key_read cycle and during the whole expansion.
- R8: Changes on key_in and key_avail during expansion have no effect on the result and raise no key_read.
- R9: rk_data combinationally returns table word S[rk_addr]. For rk_addr of 26 or more it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 128 | Secret key, byte n on bits 8n+7:8n |
| key_avail | input | 1 | Source has a key to offer |
| key_read | output | 1 | Key taken at the end of this cycle |
| cycle_num | output | 7 | Mixing iteration index, 0 outside mixing |
| keys_ready | output | 1 | Round-key table is valid |
| rk_addr | input | 5 | Round-key word index |
| rk_data | output | 32 | Round-key word at rk_addr |

## Verification
The bench counts rising edges from the edge that samples key_avail and checks every output at the falling edge after each one:
- key_read is due after edge 1 only.
- cycle_num reads 0 through edge 27, then counts from 0 after edge 28 up to 77 after edge 105.
- keys_ready is due after edge 106 and not before.

Reads of the table are combinational, so each address is checked a short delay after it is driven. The bench computes the expected words with its own model of the expansion, for several key patterns. One run changes key_in and holds key_avail high during expansion, and the result is still checked against the first key.

// File: rtl/rc5ks_pkg.sv
package rc5ks_pkg;

    localparam int          WORD_W  = 32;
    localparam logic [31:0] MAGIC_P = 32'hB7E15163;
    localparam logic [31:0] MAGIC_Q = 32'h9E3779B9;

    typedef enum logic [2:0] {
        KS_IDLE,
        KS_LOAD,
        KS_INIT,
        KS_MIX,
        KS_READY
    } ks_state_t;

    // left rotate of a 32-bit word by 0..31 places
    function automatic logic [31:0] rotl32(input logic [31:0] v, input logic [4:0] s);
        logic [63:0] d;
        d = {v, v} << s;
        return d[63:32];
    endfunction

endpackage

// File: rtl/rc5ks_ctrl.sv
module rc5ks_ctrl
    import rc5ks_pkg::*;
#(
    parameter int T    = 26,
    parameter int C    = 4,
    parameter int ITER = 78,
    parameter int TW   = 5,
    parameter int CWS  = 2,
    parameter int NW   = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           key_avail,
    output logic           start,
    output logic           init_we,
    output logic           mix_en,
    output logic [TW-1:0]  s_idx,
    output logic [CWS-1:0] l_idx,
    output logic [NW-1:0]  cycle_num,
    output logic           key_read,
    output logic           keys_ready
);

    localparam logic [TW-1:0]  SI_LAST  = TW'(T - 1);
    localparam logic [CWS-1:0] LJ_LAST  = CWS'(C - 1);
    localparam logic [NW-1:0]  CNT_LAST = NW'(ITER - 1);

    ks_state_t       state_q, state_d;
    logic [NW-1:0]   cnt_q;
    logic [TW-1:0]   si_q;
    logic [CWS-1:0]  lj_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE:  if (key_avail) state_d = KS_LOAD;
            KS_LOAD:  state_d = KS_INIT;
            KS_INIT:  if (si_q == SI_LAST) state_d = KS_MIX;
            KS_MIX:   if (cnt_q == CNT_LAST) state_d = KS_READY;
            KS_READY: if (key_avail) state_d = KS_LOAD;
            default:  state_d = KS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    // sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            si_q  <= '0;
            lj_q  <= '0;
        end else begin
            unique case (state_q)
                KS_LOAD: begin
                    cnt_q <= '0;
                    si_q  <= '0;
                    lj_q  <= '0;
                end
                KS_INIT: begin
                    si_q <= (si_q == SI_LAST) ? '0 : si_q + 1'b1;
                end
                KS_MIX: begin
                    cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
                    si_q  <= (si_q == SI_LAST) ? '0 : si_q + 1'b1;
                    lj_q  <= (lj_q == LJ_LAST) ? '0 : lj_q + 1'b1;
                end
                default: begin
                    cnt_q <= cnt_q;
                end
            endcase
        end
    end

    // output decode
    always_comb begin
        start      = 1'b0;
        init_we    = 1'b0;
        mix_en     = 1'b0;
        key_read   = 1'b0;
        keys_ready = 1'b0;
        cycle_num  = '0;
        unique case (state_q)
            KS_IDLE:  ;
            KS_LOAD: begin
                start    = 1'b1;
                key_read = 1'b1;
            end
            KS_INIT:  init_we = 1'b1;
            KS_MIX: begin
                mix_en    = 1'b1;
                cycle_num = cnt_q;
            end
            KS_READY: keys_ready = 1'b1;
            default:  ;
        endcase
    end

    assign s_idx = si_q;
    assign l_idx = lj_q;

endmodule

// File: rtl/rc5ks_table.sv
module rc5ks_table #(
    parameter int T  = 26,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [TW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [TW-1:0] mix_addr,
    output logic [31:0]   mix_data,
    input  logic [TW-1:0] rk_addr,
    output logic [31:0]   rk_data
);

    logic [31:0] mem [T];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign mix_data = mem[mix_addr];

    always_comb begin
        if (int'(rk_addr) < T) rk_data = mem[rk_addr];
        else                   rk_data = '0;
    end

endmodule

// File: rtl/rc5ks_mix.sv
module rc5ks_mix
    import rc5ks_pkg::*;
#(
    parameter int C    = 4,
    parameter int KEYW = 128,
    parameter int CWS  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            init_we,
    input  logic            mix_en,
    input  logic [KEYW-1:0] key_in,
    input  logic [CWS-1:0]  l_idx,
    input  logic [31:0]     s_rd,
    output logic [31:0]     s_wdata
);

    localparam int PADW = C * WORD_W;

    logic [PADW-1:0] key_pad;
    logic [31:0]     l_q [C];
    logic [31:0]     a_q, b_q, init_q;
    logic [31:0]     a_new, ab_sum, b_new;

    generate
        if (KEYW >= PADW) begin : g_nopad
            assign key_pad = key_in[PADW-1:0];
        end else begin : g_pad
            assign key_pad = {{(PADW-KEYW){1'b0}}, key_in};
        end
    endgenerate

    always_comb begin
        a_new  = rotl32(s_rd + a_q + b_q, 5'd3);
        ab_sum = a_new + b_q;
        b_new  = rotl32(l_q[l_idx] + ab_sum, ab_sum[4:0]);
    end

    genvar k;
    generate
        for (k = 0; k < C; k++) begin : g_lword
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                         l_q[k] <= '0;
                else if (start)                     l_q[k] <= key_pad[k*WORD_W +: WORD_W];
                else if (mix_en && int'(l_idx) == k) l_q[k] <= b_new;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            init_q <= MAGIC_P;
        end else if (start) begin
            a_q    <= '0;
            b_q    <= '0;
            init_q <= MAGIC_P;
        end else if (init_we) begin
            init_q <= init_q + MAGIC_Q;
        end else if (mix_en) begin
            a_q <= a_new;
            b_q <= b_new;
        end
    end

    assign s_wdata = init_we ? init_q : a_new;

endmodule

// File: rtl/rc5_keysched.sv
module rc5_keysched #(
    parameter int ROUNDS    = 12,
    parameter int KEY_BYTES = 16,
    localparam int T    = 2 * ROUNDS + 2,
    localparam int C    = (KEY_BYTES == 0) ? 1 : (KEY_BYTES + 3) / 4,
    localparam int ITER = 3 * ((T > C) ? T : C),
    localparam int TW   = $clog2(T),
    localparam int NW   = $clog2(ITER),
    localparam int CWS  = (C > 1) ? $clog2(C) : 1,
    localparam int KEYW = (KEY_BYTES == 0) ? 1 : 8 * KEY_BYTES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [KEYW-1:0] key_in,
    input  logic            key_avail,
    output logic            key_read,
    output logic [NW-1:0]   cycle_num,
    output logic            keys_ready,
    input  logic [TW-1:0]   rk_addr,
    output logic [31:0]     rk_data
);

    logic           start, init_we, mix_en;
    logic [TW-1:0]  s_idx;
    logic [CWS-1:0] l_idx;
    logic [31:0]    s_rd, s_wdata;

    rc5ks_ctrl #(
        .T(T), .C(C), .ITER(ITER), .TW(TW), .CWS(CWS), .NW(NW)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_avail  (key_avail),
        .start      (start),
        .init_we    (init_we),
        .mix_en     (mix_en),
        .s_idx      (s_idx),
        .l_idx      (l_idx),
        .cycle_num  (cycle_num),
        .key_read   (key_read),
        .keys_ready (keys_ready)
    );

    rc5ks_mix #(
        .C(C), .KEYW(KEYW), .CWS(CWS)
    ) mix_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .init_we (init_we),
        .mix_en  (mix_en),
        .key_in  (key_in),
        .l_idx   (l_idx),
        .s_rd    (s_rd),
        .s_wdata (s_wdata)
    );

    rc5ks_table #(
        .T(T), .TW(TW)
    ) table_i (
        .clk      (clk),
        .we       (init_we | mix_en),
        .waddr    (s_idx),
        .wdata    (s_wdata),
        .mix_addr (s_idx),
        .mix_data (s_rd),
        .rk_addr  (rk_addr),
        .rk_data  (rk_data)
    );

endmodule

// File: rtl/rc5ks_checker.sv
module rc5ks_checker #(
    parameter int ROUNDS    = 12,
    parameter int KEY_BYTES = 16,
    localparam int T    = 2 * ROUNDS + 2,
    localparam int C    = (KEY_BYTES == 0) ? 1 : (KEY_BYTES + 3) / 4,
    localparam int ITER = 3 * ((T > C) ? T : C),
    localparam int TW   = $clog2(T),
    localparam int NW   = $clog2(ITER)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          key_avail,
    input logic          key_read,
    input logic [NW-1:0] cycle_num,
    input logic          keys_ready,
    input logic [TW-1:0] rk_addr,
    input logic [31:0]   rk_data
);

    // R2: acknowledge lasts one cycle and follows a sampled key_avail
    a_r2_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        key_read |=> !key_read);
    a_r2_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_read) |-> $past(key_avail));

    // R5: ready rises only right after the last mixing iteration
    a_r5_ready_after_mix: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(keys_ready) |-> $past(cycle_num) == NW'(ITER - 1));

    // R6: iteration index steps by one
    a_r6_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_num != '0) |-> cycle_num == $past(cycle_num) + NW'(1));

    // R7: ready held until a new key, and low while acknowledging
    a_r7_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (keys_ready && !key_avail) |=> keys_ready);
    a_r7_clear_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        key_read |-> !keys_ready);

    // R8: no acknowledge while mixing is under way
    a_r8_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_num != '0) |=> !key_read);

    // R9: reads beyond the table return zero
    a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rk_addr) >= T) |-> rk_data == 32'd0);

endmodule

bind rc5_keysched rc5ks_checker #(
    .ROUNDS(ROUNDS), .KEY_BYTES(KEY_BYTES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_avail  (key_avail),
    .key_read   (key_read),
    .cycle_num  (cycle_num),
    .keys_ready (keys_ready),
    .rk_addr    (rk_addr),
    .rk_data    (rk_data)
);

// File: tb/rc5_keysched_tb_top.sv
`timescale 1ns/1ps
module rc5_keysched_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] key_in;
    logic         key_avail;
    logic         key_read;
    logic [6:0]   cycle_num;
    logic         keys_ready;
    logic [4:0]   rk_addr;
    logic [31:0]  rk_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [31:0] exp_s [26];

    always #5 clk = ~clk;

    rc5_keysched dut_i (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_avail(key_avail),
        .key_read(key_read), .cycle_num(cycle_num), .keys_ready(keys_ready),
        .rk_addr(rk_addr), .rk_data(rk_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rol(input logic [31:0] v, input int s);
        int m;
        m = s % 32;
        if (m == 0) return v;
        return (v << m) | (v >> (32 - m));
    endfunction

    // independent expansion model (R2 byte order, R3 table start, R4 loop)
    task automatic model(input logic [127:0] k);
        logic [31:0] lw [4];
        logic [31:0] a, b;
        int i, j;
        for (int w = 0; w < 4; w++) begin
            lw[w] = 32'd0;
            for (int by = 3; by >= 0; by--)
                lw[w] = (lw[w] << 8) | 32'(k[8*(4*w+by) +: 8]);
        end
        for (int n = 0; n < 26; n++) exp_s[n] = 32'hB7E15163 + 32'(n) * 32'h9E3779B9;
        a = 0; b = 0; i = 0; j = 0;
        for (int n = 0; n < 78; n++) begin
            a = rol(exp_s[i] + a + b, 3);
            exp_s[i] = a;
            b = rol(lw[j] + a + b, int'((a + b) & 32'd31));
            lw[j] = b;
            i = (i + 1) % 26;
            j = (j + 1) % 4;
        end
    endtask

    task automatic run_key(input logic [127:0] k, input bit disturb);
        int n;
        int bad_read, bad_cyc;
        model(k);
        @(negedge clk);
        key_in    = k;
        key_avail = 1'b1;
        n = 0; bad_read = 0; bad_cyc = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) begin
                chk(key_read == 1'b1, "R2 key_read after accept", 64'(key_read), 64'd1);
                chk(keys_ready == 1'b0, "R7 ready cleared on accept", 64'(keys_ready), 64'd0);
                key_avail = 1'b0;
            end else begin
                if (key_read) bad_read++;
                if (n < 106) begin
                    if (n >= 28 && n <= 105) begin
                        if (int'(cycle_num) != n - 28) bad_cyc++;
                    end else if (cycle_num != 7'd0) bad_cyc++;
                end
            end
            if (disturb && n == 2) begin
                key_in    = ~k;
                key_avail = 1'b1;
            end
            if (disturb && n == 100) key_avail = 1'b0;
        end while (!keys_ready && n < 300);
        chk(n == 106, "R5 ready latency", 64'(n), 64'd106);
        chk(bad_read == 0, "R8 no key_read during expansion", 64'(bad_read), 64'd0);
        chk(bad_cyc == 0, "R6 cycle_num sequence", 64'(bad_cyc), 64'd0);
        chk(cycle_num == 7'd0, "R6 cycle_num zero when ready", 64'(cycle_num), 64'd0);
        repeat (3) @(negedge clk);
        chk(keys_ready == 1'b1, "R7 ready held", 64'(keys_ready), 64'd1);
        for (int a = 0; a < 32; a++) begin
            rk_addr = 5'(a);
            #1;
            if (a < 26)
                chk(rk_data == exp_s[a], disturb ? "R8 R3 R4 table word" : "R3 R4 R9 table word",
                    64'(rk_data), 64'(exp_s[a]));
            else
                chk(rk_data == 32'd0, "R9 out-of-range read", 64'(rk_data), 64'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [127:0] kv;
        rst_n = 1'b0; key_avail = 1'b0; key_in = '0; rk_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(key_read == 1'b0, "R1 key_read reset", 64'(key_read), 64'd0);
        chk(keys_ready == 1'b0, "R1 keys_ready reset", 64'(keys_ready), 64'd0);
        chk(cycle_num == 7'd0, "R1 cycle_num reset", 64'(cycle_num), 64'd0);
        repeat (4) @(negedge clk);
        chk(keys_ready == 1'b0, "R2 idle without key_avail", 64'(keys_ready), 64'd0);

        run_key('0, 1'b0);
        run_key({128{1'b1}}, 1'b0);
        for (int b = 0; b < 16; b++) kv[8*b +: 8] = 8'(b);
        run_key(kv, 1'b1);
        kv = 128'h0123456789ABCDEF_FEDCBA9876543210;
        run_key(kv, 1'b0);
        for (int b = 0; b < 16; b++) kv[8*b +: 8] = 8'(8'h80 >> (b % 8)) ^ 8'(b * 37);
        run_key(kv, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule